// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity for profiling software. It holds one cycle counter that runs on every clock while enabled, and a small bank of event counters. Each event counter is bound by a programmable event number to one line of a vector of single-cycle event pulses. Software programs and reads the unit over a simple register bus with one access strobe per cycle. The bus carries an address, a write strobe, a read strobe, write data, read data and a privilege flag.

Event counters have no address of their own. Software first writes an index to a select register. The event-type and event-count registers then act on the counter that index names. Event counters advance only while one of two debug-permission inputs is high, while the cycle counter ignores those inputs. A user-access register decides whether non-privileged bus accesses are honoured. A refused access returns zero, changes nothing and raises an error flag.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every counter, the global enable, the enable mask, the select index, the event numbers and the user-access bit are zero, and bus_err is low.
- R2: Bit 0 of the control register (address 0x0) is the global enable and reads back; while it is 0 no counter changes except through a bus clear or write.
- R3: Writing 1 to control bit 1 clears every event counter at that clock edge; the bit is not stored and reads as 0.
- R4: Writing 1 to control bit 2 clears the cycle counter at that edge and is not stored; a single write of 0x7 enables counting and clears both kinds of counter, and counting starts on the following edge.
- R5: Writing to address 0x1 sets the enable-mask bits written as 1, with bit 31 for the cycle counter and bit N for event counter N. Writing to address 0x2 clears the bits written as 1. Both addresses read the current mask, and unused bits read as 0.
- R6: Address 0x3 holds the select index in bits 4:0. Address 0x4 (event number, bits 7:0) and address 0x5 (count value) read and write the event counter the index names.
- R7: An event counter increments by exactly one on each clock edge where the global enable is 1, its mask bit is 1, debug permission is present, and the event input its event number names is high.
- R8: Event counters advance only while dbg_en or nidbg_en is high; the cycle counter, when enabled, counts on every edge regardless of them.
- R9: An event number of 16 or more counts nothing. A select index of 4 or more makes addresses 0x4 and 0x5 read as 0 and ignore writes.
- R10: User-access bit 0 at address 0x7 lets non-privileged accesses through. Only privileged accesses may reach address 0x7, and the bit has no effect on counting.
- R11: A refused non-privileged access returns read data 0 and changes no state, and bus_err is high for the single cycle after it.
- R12: Counters are 32 bits wide and wrap from 0xFFFFFFFF to 0. The cycle counter can be written at address 0x6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | High for a privileged access |
| bus_rdata | output | 32 | Read data, combinational from the address while bus_rd is high |
| bus_err | output | 1 | One-cycle flag after a refused access |
| evt_in | input | 16 | Single-cycle event pulses, one line per event number |
| dbg_en | input | 1 | Invasive debug permission |
| nidbg_en | input | 1 | Non-invasive debug permission |

## Verification
The assertions assume at most one of bus_wr and bus_rd is high in a cycle. They also assume the bus signals and event pulses are stable across each clock edge. The bench drives every input on the falling edge and holds it for a whole cycle, and it never raises both strobes together. Event pulses are held for whole cycles, so the expected counts are the number of rising edges during which a pulse was high. The expected values are derived from the stated edge on which each write takes effect.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int CYC_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 4'h0,
    REG_ENSET  = 4'h1,
    REG_ENCLR  = 4'h2,
    REG_SELECT = 4'h3,
    REG_EVTYPE = 4'h4,
    REG_EVCNT  = 4'h5,
    REG_CYCCNT = 4'h6,
    REG_USRACC = 4'h7
  } pmu_reg_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_EVCLR_BIT = 1;
  localparam int CTRL_CYCLR_BIT = 2;

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (ld)     cnt <= ld_val;
    else if (inc)    cnt <= bump(cnt);
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld) |=> cnt == $past(cnt) + W'(1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr && !ld) |=> $stable(cnt));

endmodule

// File: rtl/pmu_access_guard.sv
module pmu_access_guard #(
  parameter int              AW        = 4,
  parameter logic [AW-1:0]   PROT_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          priv,
  input  logic          user_en,
  input  logic [AW-1:0] addr,
  output logic          allow,
  output logic          err
);

  logic deny;

  assign deny  = acc && !priv && (!user_en || addr == PROT_ADDR);
  assign allow = acc && !deny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= deny;
  end

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !priv && !user_en) |=> err);

  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc || priv) |=> !err);

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 16,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 5,
  parameter int ET_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_priv,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_err,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic              dbg_en,
  input  logic              nidbg_en
);

  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  function automatic logic evt_valid(input logic [ET_W-1:0] n);
    return 32'(n) < NUM_EVT;
  endfunction

  function automatic logic evt_hit(input logic [NUM_EVT-1:0] v,
                                   input logic [ET_W-1:0] n);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NUM_EVT; k++)
      if (32'(n) == k) h = v[k];
    return h;
  endfunction

  function automatic logic sel_valid(input logic [SEL_W-1:0] s);
    return 32'(s) < NUM_CNT;
  endfunction

  // programmed state
  logic                glb_en;
  logic                cyc_en;
  logic [NUM_CNT-1:0]  evt_en;
  logic [SEL_W-1:0]    sel;
  logic [ET_W-1:0]     evtype [NUM_CNT];
  logic                user_en;

  // named internal events
  logic                acc_allow;
  logic                wr_ok;
  logic                sel_ok;
  logic [IDX_W-1:0]    sel_idx;
  logic                count_gate;
  logic                cyc_inc;
  logic [NUM_CNT-1:0]  evt_inc;
  logic [NUM_CNT-1:0]  evt_ld;
  logic                evt_clr;
  logic                cyc_clr;
  logic                cyc_ld;
  logic [CNT_W-1:0]    cyc_cnt;
  logic [CNT_W-1:0]    evt_cnt [NUM_CNT];

  pmu_access_guard #(
    .AW        (ADDR_W),
    .PROT_ADDR (REG_USRACC)
  ) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (bus_wr || bus_rd),
    .priv    (bus_priv),
    .user_en (user_en),
    .addr    (bus_addr),
    .allow   (acc_allow),
    .err     (bus_err)
  );

  assign wr_ok      = bus_wr && acc_allow;
  assign sel_ok     = sel_valid(sel);
  assign sel_idx    = sel[IDX_W-1:0];
  assign count_gate = glb_en && (dbg_en || nidbg_en);
  assign cyc_inc    = glb_en && cyc_en;
  assign evt_clr    = wr_ok && bus_addr == REG_CTRL && bus_wdata[CTRL_EVCLR_BIT];
  assign cyc_clr    = wr_ok && bus_addr == REG_CTRL && bus_wdata[CTRL_CYCLR_BIT];
  assign cyc_ld     = wr_ok && bus_addr == REG_CYCCNT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      cyc_en  <= 1'b0;
      evt_en  <= '0;
      sel     <= '0;
      user_en <= 1'b0;
    end else if (wr_ok) begin
      case (bus_addr)
        REG_CTRL:   glb_en  <= bus_wdata[CTRL_EN_BIT];
        REG_ENSET: begin
          cyc_en <= cyc_en | bus_wdata[CYC_BIT];
          evt_en <= evt_en | bus_wdata[NUM_CNT-1:0];
        end
        REG_ENCLR: begin
          cyc_en <= cyc_en & ~bus_wdata[CYC_BIT];
          evt_en <= evt_en & ~bus_wdata[NUM_CNT-1:0];
        end
        REG_SELECT: sel     <= bus_wdata[SEL_W-1:0];
        REG_USRACC: user_en <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        evtype[g] <= '0;
      else if (wr_ok && bus_addr == REG_EVTYPE && sel_ok && sel_idx == IDX_W'(g))
        evtype[g] <= bus_wdata[ET_W-1:0];
    end

    assign evt_inc[g] = count_gate && evt_en[g] && evt_hit(evt_in, evtype[g]);
    assign evt_ld[g]  = wr_ok && bus_addr == REG_EVCNT && sel_ok && sel_idx == IDX_W'(g);

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (evt_clr),
      .ld     (evt_ld[g]),
      .ld_val (bus_wdata[CNT_W-1:0]),
      .inc    (evt_inc[g]),
      .cnt    (evt_cnt[g])
    );

    assert_bad_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid(evtype[g]) |-> !evt_inc[g]);
  end

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cyc_clr),
    .ld     (cyc_ld),
    .ld_val (bus_wdata[CNT_W-1:0]),
    .inc    (cyc_inc),
    .cnt    (cyc_cnt)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && acc_allow) begin
      case (bus_addr)
        REG_CTRL:   bus_rdata[CTRL_EN_BIT] = glb_en;
        REG_ENSET, REG_ENCLR: begin
          bus_rdata[CYC_BIT]       = cyc_en;
          bus_rdata[NUM_CNT-1:0]   = evt_en;
        end
        REG_SELECT: bus_rdata[SEL_W-1:0] = sel;
        REG_EVTYPE: if (sel_ok) bus_rdata[ET_W-1:0]  = evtype[sel_idx];
        REG_EVCNT:  if (sel_ok) bus_rdata[CNT_W-1:0] = evt_cnt[sel_idx];
        REG_CYCCNT: bus_rdata[CNT_W-1:0] = cyc_cnt;
        REG_USRACC: bus_rdata[0] = user_en;
        default: ;
      endcase
    end
  end

  assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (evt_inc == '0 && !cyc_inc));

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_en || nidbg_en) |-> evt_inc == '0);

  assert_deny_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_priv && !user_en) |-> bus_rdata == '0);

  assert_user_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_priv && bus_addr == REG_USRACC) |=> $stable(user_en));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

endmodule

// File: tb/test_perf_mon_unit.sv
`timescale 1ns/1ps
module test_perf_mon_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [15:0] evt_in = '0;
  logic        dbg_en = 1'b0;
  logic        nidbg_en = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  perf_mon_unit i_perf_mon_unit (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_priv,
    .bus_rdata, .bus_err, .evt_in, .dbg_en, .nidbg_en
  );

  localparam logic [3:0] A_CTRL = 4'h0, A_SET = 4'h1, A_CLR = 4'h2, A_SEL = 4'h3,
                         A_TYPE = 4'h4, A_CNT = 4'h5, A_CYC = 4'h6, A_USR = 4'h7;

  // {write, addr, wdata, expected read}
  localparam int NV = 18;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, A_SET,  32'h8000_0005, 32'h0},
    {1'b0, A_SET,  32'h0,         32'h8000_0005},
    {1'b1, A_SET,  32'h0000_0002, 32'h0},
    {1'b0, A_CLR,  32'h0,         32'h8000_0007},
    {1'b1, A_CLR,  32'h8000_0001, 32'h0},
    {1'b0, A_SET,  32'h0,         32'h0000_0006},
    {1'b1, A_SET,  32'hFFFF_FFFF, 32'h0},
    {1'b0, A_SET,  32'h0,         32'h8000_000F},
    {1'b1, A_CLR,  32'hFFFF_FFFF, 32'h0},
    {1'b0, A_CLR,  32'h0,         32'h0},
    {1'b1, A_SEL,  32'h0000_0002, 32'h0},
    {1'b0, A_SEL,  32'h0,         32'h0000_0002},
    {1'b1, A_TYPE, 32'h0000_010B, 32'h0},
    {1'b0, A_TYPE, 32'h0,         32'h0000_000B},
    {1'b1, A_CTRL, 32'h0000_0007, 32'h0},
    {1'b0, A_CTRL, 32'h0,         32'h0000_0001},
    {1'b1, A_CTRL, 32'h0000_0006, 32'h0},
    {1'b0, A_CTRL, 32'h0,         32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called on a falling edge, returns on the next falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p);
    bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic p,
                    output logic [31:0] d, output logic e);
    bus_addr = a; bus_priv = p; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    e = bus_err;
    bus_rd = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d; logic e;
    rd(a, 1'b1, d, e);
    check(req, d, exp);
  endtask

  task automatic evcnt(input int idx, input logic [31:0] exp, input string req);
    wr(A_SEL, 32'(idx), 1'b1);
    rdchk(A_CNT, exp, req);
  endtask

  task automatic pulse(input logic [15:0] v, input int n);
    evt_in = v;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 err", {31'b0, bus_err}, 32'h0);
    rdchk(A_CTRL, 32'h0, "R1 ctrl");
    rdchk(A_SET,  32'h0, "R1 mask");
    rdchk(A_CYC,  32'h0, "R1 cycle");
    rdchk(A_CNT,  32'h0, "R1 event");
    rdchk(A_USR,  32'h0, "R1 user");

    // R5 R6 R3 R4: register vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32], 1'b1);
      else rdchk(VEC[i][67:64], VEC[i][31:0], $sformatf("R5/R6 vector %0d", i));
    end

    // R4 enable+clear with 0x7, cycle counts 6 edges
    wr(A_SET, 32'h8000_0000, 1'b1);
    wr(A_CTRL, 32'h7, 1'b1);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h0, 1'b1);
    rdchk(A_CYC, 32'd6, "R4 count after 0x7");
    repeat (3) @(negedge clk);
    rdchk(A_CYC, 32'd6, "R2 hold while disabled");
    wr(A_CTRL, 32'h4, 1'b1);
    rdchk(A_CYC, 32'd0, "R4 cycle clear");

    // R7 R9 event counting
    dbg_en = 1'b1;
    wr(A_SEL, 0, 1'b1); wr(A_TYPE, 3, 1'b1);
    wr(A_SEL, 1, 1'b1); wr(A_TYPE, 5, 1'b1);
    wr(A_SEL, 2, 1'b1); wr(A_TYPE, 20, 1'b1);
    wr(A_SEL, 3, 1'b1); wr(A_TYPE, 3, 1'b1);
    wr(A_SET, 32'h7, 1'b1);
    wr(A_CTRL, 32'h1, 1'b1);
    pulse(16'h0008, 3);
    pulse(16'h0020, 2);
    pulse(16'h0028, 1);
    pulse(16'hFFFF, 2);
    wr(A_CTRL, 32'h0, 1'b1);
    evcnt(0, 32'd6, "R7 counter0 event3");
    evcnt(1, 32'd5, "R7 counter1 event5");
    evcnt(2, 32'd0, "R9 event number 20");
    evcnt(3, 32'd0, "R5 counter3 masked off");

    // R8 gating
    dbg_en = 1'b0; nidbg_en = 1'b0;
    wr(A_CTRL, 32'h5, 1'b1);
    pulse(16'h0008, 4);
    wr(A_CTRL, 32'h0, 1'b1);
    evcnt(0, 32'd6, "R8 no event count without permission");
    rdchk(A_CYC, 32'd5, "R8 cycle runs without permission");
    nidbg_en = 1'b1;
    wr(A_CTRL, 32'h1, 1'b1);
    pulse(16'h0008, 2);
    wr(A_CTRL, 32'h0, 1'b1);
    evcnt(0, 32'd8, "R8 nidbg permits counting");

    // R3 event clear leaves cycle counter
    wr(A_CTRL, 32'h2, 1'b1);
    evcnt(0, 32'd0, "R3 counter0 cleared");
    evcnt(1, 32'd0, "R3 counter1 cleared");
    rdchk(A_CYC, 32'd8, "R3 cycle untouched");

    // R12 wrap
    wr(A_CYC, 32'hFFFF_FFFF, 1'b1);
    rdchk(A_CYC, 32'hFFFF_FFFF, "R12 cycle write");
    wr(A_CTRL, 32'h1, 1'b1);
    wr(A_CTRL, 32'h0, 1'b1);
    rdchk(A_CYC, 32'h0, "R12 cycle wrap");
    wr(A_SEL, 0, 1'b1);
    wr(A_CNT, 32'hFFFF_FFFF, 1'b1);
    rdchk(A_CNT, 32'hFFFF_FFFF, "R6 event write");
    wr(A_CTRL, 32'h1, 1'b1);
    pulse(16'h0008, 1);
    wr(A_CTRL, 32'h0, 1'b1);
    rdchk(A_CNT, 32'h0, "R12 event wrap");

    // R9 invalid select
    wr(A_CNT, 32'h55, 1'b1);
    wr(A_SEL, 6, 1'b1);
    rdchk(A_TYPE, 32'h0, "R9 type reads 0");
    rdchk(A_CNT,  32'h0, "R9 count reads 0");
    wr(A_CNT, 32'h99, 1'b1);
    wr(A_TYPE, 32'h1, 1'b1);
    wr(A_SEL, 0, 1'b1);
    rdchk(A_CNT,  32'h55, "R9 count write ignored");
    rdchk(A_TYPE, 32'h3,  "R9 type write ignored");

    // R11 R10 access control
    rd(A_SET, 1'b0, d, e);
    check("R11 denied read data", d, 32'h0);
    check("R11 denied err", {31'b0, e}, 32'h1);
    @(negedge clk);
    check("R11 err one cycle", {31'b0, bus_err}, 32'h0);
    wr(A_SEL, 3, 1'b0);
    check("R11 write err", {31'b0, bus_err}, 32'h1);
    rd(A_SEL, 1'b1, d, e);
    check("R11 denied write ignored", d, 32'h0);
    check("R11 no err when privileged", {31'b0, e}, 32'h0);
    wr(A_USR, 32'h1, 1'b1);
    rd(A_SET, 1'b0, d, e);
    check("R10 user read allowed", d, 32'h8000_0007);
    check("R10 user read no err", {31'b0, e}, 32'h0);
    wr(A_USR, 32'h0, 1'b0);
    check("R10 user reg protected err", {31'b0, bus_err}, 32'h1);
    rdchk(A_USR, 32'h1, "R10 user reg unchanged");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule